// File: doc/BRIEF.md
# Three-Level Nested Interrupt Vector Controller

This block sits in front of a small processor core and chooses which of ten interrupt vectors to dispatch. Each vector stands for a group of request sources, which are merged upstream. One configuration bit per vector selects its priority level from the three levels X, H and L. Vectors 0 and 1 can only be X or L. Vectors 2 to 9 can only be H or L.

A small stack holds the level currently in service, and this allows nested interrupts. A requesting vector is offered to the core only when its level is strictly above the level at the top of the stack. When several vectors are eligible, the highest level wins, and among vectors of equal level the lowest index wins. The dispatch output follows the requests combinationally, so it is re-evaluated in every cycle until the core acknowledges it. An acknowledge pushes the dispatched level onto the stack. A return-from-interrupt pops it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `valid_o` is high, `vec_addr_o` equals 0x00003 + 8 × k, where k (0..9) is the index of the winning vector, so the addresses run from 0x00003 to 0x0004B.
- R2: `cur_lvl_o` encodes the in-service level as 0 = none, 1 = L, 2 = H, 3 = X. After reset it is 0 and `valid_o` is low.
- R3: `lvl_sel_i[k]` set gives level X for k = 0 and 1, and level H for k = 2..9. The bit clear gives level L.
- R4: A requesting vector is dispatched only if its level is strictly greater than `cur_lvl_o`. A vector at an equal or lower level holds `valid_o` low while it waits.
- R5: Among eligible requesting vectors, the highest level wins. At equal level, the lowest index wins.
- R6: `ack_i` high while `valid_o` is high (and `reti_i` low) pushes the dispatched level. From the next cycle that level appears on `cur_lvl_o`. Up to three levels nest.
- R7: `reti_i` pops one level, so that `cur_lvl_o` returns to the level that was in service before. `reti_i` with nothing in service has no effect.
- R8: `valid_o` and `vec_addr_o` follow the current requests within the same cycle. If the request is withdrawn before the acknowledge, `valid_o` falls. `vec_addr_o` is 0 while `valid_o` is low.
- R9: `ack_i` while `valid_o` is low does not change `cur_lvl_o`.
- R10: When `reti_i` and `ack_i` are both high in one cycle, only the pop takes place and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 10 | Pending request, one bit per vector |
| lvl_sel_i | input | 10 | Level select per vector (set = raised level) |
| ack_i | input | 1 | Core takes the dispatched vector |
| reti_i | input | 1 | Core leaves the current handler |
| valid_o | output | 1 | A vector is offered for dispatch |
| vec_addr_o | output | 17 | Address of the offered vector |
| cur_lvl_o | output | 2 | Level currently in service |

## Verification
In every cycle, the assertions check that the address of an offered vector lies on the 8-byte grid and within range, and that the winner is a requesting vector. They also check that nothing is offered while X is in service. On the stack side they check that an acknowledge strictly raises the in-service level, that a return lowers the depth by one, that an acknowledge with no offer leaves the level unchanged, and that stacked levels strictly increase. Only the bench scenarios can show the full arbitration order across mixed levels, the mapping of the level-select bits, and the restoration of earlier levels through a complete nest and unwind. The same holds for the conflict between a simultaneous acknowledge and return, and for the withdrawal of a waiting request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 2;
  typedef enum logic [LVL_W-1:0] {
    LVL_NONE = 2'd0,
    LVL_L    = 2'd1,
    LVL_H    = 2'd2,
    LVL_X    = 2'd3
  } lvl_e;
  // one stack slot per level above NONE
  localparam int NEST_DEPTH = 3;
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_pkg::*;
#(
  parameter int N_VEC = 10,
  parameter int N_TOP = 2
) (
  input  logic [N_VEC-1:0]            lvl_sel_i,
  output logic [N_VEC-1:0][LVL_W-1:0] lvl_o
);
  for (genvar g = 0; g < N_VEC; g++) begin : g_map
    if (g < N_TOP) begin : g_top
      assign lvl_o[g] = lvl_sel_i[g] ? LVL_X : LVL_L;
    end else begin : g_mid
      assign lvl_o[g] = lvl_sel_i[g] ? LVL_H : LVL_L;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_VEC = 10,
  localparam int IDX_W = $clog2(N_VEC)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_VEC-1:0]            req_i,
  input  logic [N_VEC-1:0][LVL_W-1:0] lvl_i,
  output logic                        win_valid_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output lvl_e                        win_lvl_o
);
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_lvl_o   = LVL_NONE;
    // strict compare: the first (lowest) index keeps a tie
    for (int i = 0; i < N_VEC; i++) begin
      if (req_i[i] && (lvl_i[i] > win_lvl_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_lvl_o   = lvl_e'(lvl_i[i]);
      end
    end
  end

  p_win_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (req_i[win_idx_o] && (lvl_i[win_idx_o] == win_lvl_o)));
  p_win_any_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> win_valid_o);
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = NEST_DEPTH,
  localparam int DEP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  lvl_e             push_lvl_i,
  output lvl_e             cur_lvl_o,
  output logic [DEP_W-1:0] depth_o
);
  lvl_e             stk_q [DEPTH];
  logic [DEP_W-1:0] dep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dep_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= LVL_NONE;
    end else if (pop_i) begin
      if (dep_q != '0) dep_q <= dep_q - 1'b1;
    end else if (push_i && (dep_q < DEP_W'(DEPTH))) begin
      for (int i = 0; i < DEPTH; i++)
        if (DEP_W'(i) == dep_q) stk_q[i] <= push_lvl_i;
      dep_q <= dep_q + 1'b1;
    end
  end

  always_comb begin
    cur_lvl_o = LVL_NONE;
    for (int i = 0; i < DEPTH; i++)
      if (DEP_W'(i + 1) == dep_q) cur_lvl_o = stk_q[i];
  end

  assign depth_o = dep_q;

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dep_q <= DEP_W'(DEPTH));
  p_pop_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && dep_q != '0) |=> (dep_q == $past(dep_q) - 1'b1));
  p_pop_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && dep_q == '0) |=> (dep_q == '0));
  p_stack_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dep_q >= DEP_W'(2)) |-> (stk_q[1] > stk_q[0]));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int N_VEC     = 10,
  parameter int N_TOP     = 2,
  parameter int ADDR_W    = 17,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8,
  localparam int IDX_W    = $clog2(N_VEC),
  localparam int DEP_W    = $clog2(NEST_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_VEC-1:0]  req_i,
  input  logic [N_VEC-1:0]  lvl_sel_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [LVL_W-1:0]  cur_lvl_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(VEC_STEP);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(VEC_BASE + VEC_STEP * (N_VEC - 1));

  logic [N_VEC-1:0][LVL_W-1:0] vec_lvl;
  logic                        win_valid;
  logic [IDX_W-1:0]            win_idx;
  lvl_e                        win_lvl;
  lvl_e                        cur_lvl;
  logic [DEP_W-1:0]            depth;
  logic                        accept;

  irq_level_map #(.N_VEC(N_VEC), .N_TOP(N_TOP)) u_map (
    .lvl_sel_i (lvl_sel_i),
    .lvl_o     (vec_lvl)
  );

  irq_arbiter #(.N_VEC(N_VEC)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .lvl_i       (vec_lvl),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_lvl_o   (win_lvl)
  );

  // nesting only upward: strictly above what is in service
  assign accept = win_valid && (win_lvl > cur_lvl);

  irq_level_stack #(.DEPTH(NEST_DEPTH)) u_stk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ack_i && accept),
    .pop_i      (reti_i),
    .push_lvl_i (win_lvl),
    .cur_lvl_o  (cur_lvl),
    .depth_o    (depth)
  );

  assign valid_o    = accept;
  assign vec_addr_o = accept ? (BASE_A + STEP_A * ADDR_W'(win_idx)) : '0;
  assign cur_lvl_o  = cur_lvl;

  p_addr_grid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (((vec_addr_o - BASE_A) % STEP_A) == '0 &&
                 vec_addr_o >= BASE_A && vec_addr_o <= LAST_A));
  p_top_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_lvl_o == LVL_X) |-> !valid_o);
  p_ack_raises_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && valid_o && !reti_i) |=> (cur_lvl_o > $past(cur_lvl_o)));
  p_ack_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !valid_o && !reti_i) |=> $stable(cur_lvl_o));
  p_reti_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && reti_i && depth != '0) |=> (depth == $past(depth) - 1'b1));
  p_idle_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (vec_addr_o == '0));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  localparam int N = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  sel = '0;
  logic          ack = 1'b0;
  logic          reti = 1'b0;
  logic          valid;
  logic [16:0]   addr;
  logic [1:0]    lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        v;
    logic [16:0] a;
    logic [1:0]  l;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  event item_ev;

  always #2.5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .lvl_sel_i(sel),
    .ack_i(ack), .reti_i(reti), .valid_o(valid), .vec_addr_o(addr),
    .cur_lvl_o(lvl)
  );

  function automatic logic [16:0] va(int k);
    return 17'(3 + 8 * k);
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pop expected item and compare with live outputs
  initial begin
    forever begin
      @(item_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.tag, "valid", int'(valid), int'(e.v));
        cmp(e.tag, "addr",  int'(addr),  int'(e.a));
        cmp(e.tag, "level", int'(lvl),   int'(e.l));
      end
    end
  end

  // driver: apply inputs for one cycle, queue the expected outputs
  task automatic step(logic [N-1:0] r, logic [N-1:0] s, logic a, logic ri,
                      logic ev, logic [16:0] ea, logic [1:0] el, string tag);
    exp_t e;
    @(negedge clk);
    req = r; sel = s; ack = a; reti = ri;
    #1;
    e.v = ev; e.a = ea; e.l = el; e.tag = tag;
    sb_q.push_back(e);
    ->item_ev;
  endtask

  initial begin
    #(5.0 * 2000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    step('0, '0, 0, 0, 0, '0, 2'd0, "R2 reset");
    @(negedge clk); rst_n = 1'b1;
    step('0, '0, 0, 0, 0, '0, 2'd0, "R2 idle");
    // single L request above none
    step(10'b00_0010_0000, '0, 0, 0, 1, va(5), 2'd0, "R1 R4 vec5");
    // two L: lowest index
    step(10'b00_0010_1000, '0, 0, 0, 1, va(3), 2'd0, "R5 tie");
    // vec7 raised to H beats vec3 at L
    step(10'b00_1000_1000, 10'b00_1000_0000, 0, 0, 1, va(7), 2'd0, "R3 R5 H over L");
    // vec1 at L loses to vec7 at H
    step(10'b00_1000_0010, 10'b00_1000_0000, 0, 0, 1, va(7), 2'd0, "R3 low vec at L");
    // vec1 raised to X wins
    step(10'b00_1000_0010, 10'b00_1000_0010, 0, 0, 1, va(1), 2'd0, "R3 R5 X wins");
    // vec2 raised is H, not X: vec7 H with lower? vec2 index lower wins tie
    step(10'b00_1000_0100, 10'b00_1000_0100, 0, 0, 1, va(2), 2'd0, "R3 vec2 is H");
    // take vec9 at L
    step(10'b10_0000_0000, '0, 1, 0, 1, va(9), 2'd0, "R6 ack L");
    step(10'b10_0000_0000, '0, 0, 0, 0, '0, 2'd1, "R4 equal waits");
    step(10'b00_0001_0000, 10'b00_0001_0000, 1, 0, 1, va(4), 2'd1, "R6 ack H");
    step(10'b00_0100_0000, 10'b00_0100_0000, 0, 0, 0, '0, 2'd2, "R4 H waits under H");
    step(10'b00_0100_0001, 10'b00_0100_0001, 1, 0, 1, va(0), 2'd2, "R6 ack X");
    step('1, '1, 0, 0, 0, '0, 2'd3, "R4 nothing above X");
    step(10'b00_0000_0000, '0, 1, 0, 0, '0, 2'd3, "R9 ack idle");
    step('0, '0, 0, 1, 0, '0, 2'd3, "R9 level kept");
    step('0, '0, 0, 1, 0, '0, 2'd2, "R7 back to H");
    step(10'b00_0001_0000, 10'b00_0001_0000, 1, 1, 1, va(4), 2'd1, "R7 back to L");
    step('0, '0, 0, 1, 0, '0, 2'd0, "R10 ack ignored");
    step('0, '0, 0, 0, 0, '0, 2'd0, "R7 empty pop ignored");
    step(10'b00_0000_0100, '0, 0, 0, 1, va(2), 2'd0, "R8 offer");
    step('0, '0, 0, 0, 0, '0, 2'd0, "R8 withdrawn");
    step(10'b00_0000_0001, 10'b00_0000_0001, 1, 0, 1, va(0), 2'd0, "R6 X from none");
    step('0, '0, 0, 0, 0, '0, 2'd3, "R6 X in service");
    @(negedge clk);
    if (sb_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard left %0d items", sb_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule